// File: doc/BRIEF.md
# Command Completion Tracker with Interrupt Coalescing

This block keeps per-slot bookkeeping for up to sixteen commands handed to a storage-link controller. An issue strobe marks a slot as outstanding. A completion strobe moves that slot from outstanding to completed. An error strobe records a failing slot, raises a device-error flag and freezes the command queue. Host software sees all of this through a small register port. It acknowledges completions and clears errors by writing ones.

The host interrupt is paced by a coalescing timer. The timer loads a programmable cycle count when the first completion bit appears. It counts down while any completion bit is set and pulses the interrupt each time it runs out. Every acknowledge of a set completion bit restarts it. After a device error the queue stays stopped until software has cleared both the device-error flag and every per-slot error bit. On release, the aborted outstanding slots are discarded so that software can reissue them. While the queue is stopped, issue attempts are refused and reported on a reject pulse.

Top module: `cplq_tracker`

## Requirements
- R1: After reset, the QUEUED (address 0), DONE (address 1) and FAULT (address 2) registers read zero, and DEVFLT (address 3, flag in bit 0) reads zero. TIMEOUT (address 4, bits 15..0) reads its reset value of 8, and irq, queue_stopped and issue_rejected are low.
- R2: An accepted issue strobe sets bit issue_slot of QUEUED one cycle later. QUEUED is read-only, so a host write to address 0 leaves it unchanged.
- R3: A completion strobe while the queue runs clears bit done_slot of QUEUED and sets bit done_slot of DONE. Bits 31..16 of QUEUED, DONE and FAULT always read zero.
- R4: Writing 1 to a DONE bit clears it. A DONE bit written with 0 keeps its value.
- R5: When a completion sets the first DONE bit, the timer loads TIMEOUT. irq then pulses high for one cycle TIMEOUT+1 cycles after that completion is sampled, and again every TIMEOUT+1 cycles while DONE is non-zero.
- R6: A write-1 to a DONE bit that is set is an acknowledge. It restarts the count, so the next irq comes TIMEOUT+1 cycles after the acknowledge is sampled. A further completion while DONE is already non-zero does not restart the count.
- R7: irq never pulses while DONE is zero. Clearing every DONE bit before the count runs out suppresses the interrupt.
- R8: An error strobe sets bit fault_slot of FAULT. Writing 1 to a FAULT bit clears it, and writing 0 leaves it.
- R9: An error strobe sets the DEVFLT flag and raises queue_stopped one cycle later. While the queue is stopped, QUEUED keeps the slots that were outstanding, and completion strobes change neither QUEUED nor DONE.
- R10: While queue_stopped is high, an issue strobe does not touch QUEUED, and issue_rejected is high for exactly the following cycle.
- R11: Writing 1 to DEVFLT bit 0 clears the flag. queue_stopped falls only once the flag and all FAULT bits are clear. It falls in the cycle after the last clearing write, and at that point QUEUED is cleared and issues are accepted again.
- R12: TIMEOUT is read/write in bits 15..0. A new value is used from the next load of the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Issue strobe for issue_slot |
| issue_slot | input | 4 | Slot being issued |
| done_valid | input | 1 | Completion strobe for done_slot |
| done_slot | input | 4 | Slot that completed |
| fault_valid | input | 1 | Device-error strobe for fault_slot |
| fault_slot | input | 4 | Slot that failed |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr (same cycle) |
| irq | output | 1 | Coalesced interrupt pulse |
| queue_stopped | output | 1 | Queue frozen after a device error |
| issue_rejected | output | 1 | An issue was refused in the previous cycle |

## Verification
The hardest situation to reach from the ports is the release of a stopped queue. It needs outstanding slots, an error and then a refused issue and an ignored completion in the frozen state. After that come two separate clearing writes, and only the second of them may release the queue. The bench builds this in a fixed order and checks queue_stopped and QUEUED after each write. The acknowledge restart is separated from free-running expiry by acknowledging a few cycles after an interrupt, so that the two give different delays.

// File: rtl/cplq_pkg.sv
package cplq_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_QUEUED = 3'd0,
      RA_DONE   = 3'd1,
      RA_FAULT  = 3'd2,
      RA_DEVFLT = 3'd3,
      RA_TMO    = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/cplq_slot_regs.sv
module cplq_slot_regs #(
   parameter int NUM_SLOTS = 16,
   parameter int SLOT_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue_en_i,
   input  logic [SLOT_W-1:0]    issue_slot_i,
   input  logic                 done_en_i,
   input  logic [SLOT_W-1:0]    done_slot_i,
   input  logic                 fault_en_i,
   input  logic [SLOT_W-1:0]    fault_slot_i,
   input  logic [NUM_SLOTS-1:0] done_clr_i,
   input  logic [NUM_SLOTS-1:0] fault_clr_i,
   input  logic                 abort_i,
   input  logic                 stopped_i,
   output logic [NUM_SLOTS-1:0] queued_o,
   output logic [NUM_SLOTS-1:0] done_o,
   output logic [NUM_SLOTS-1:0] fault_o,
   output logic                 done_first_o,
   output logic                 fault_any_next_o
);
   logic [NUM_SLOTS-1:0] queued_q, done_q, fault_q;
   logic [NUM_SLOTS-1:0] queued_n, done_n, fault_n;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic issue_hit, done_hit, fault_hit;
      assign issue_hit = issue_en_i && (issue_slot_i == SLOT_W'(i));
      assign done_hit  = done_en_i  && (done_slot_i  == SLOT_W'(i));
      assign fault_hit = fault_en_i && (fault_slot_i == SLOT_W'(i));

      always_comb begin
         if (abort_i)
            queued_n[i] = 1'b0;
         else if (issue_hit)
            queued_n[i] = 1'b1;
         else if (done_hit)
            queued_n[i] = 1'b0;
         else
            queued_n[i] = queued_q[i];
         done_n[i]  = done_hit  | (done_q[i]  & ~done_clr_i[i]);
         fault_n[i] = fault_hit | (fault_q[i] & ~fault_clr_i[i]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            queued_q[i] <= 1'b0;
            done_q[i]   <= 1'b0;
            fault_q[i]  <= 1'b0;
         end else begin
            queued_q[i] <= queued_n[i];
            done_q[i]   <= done_n[i];
            fault_q[i]  <= fault_n[i];
         end
      end
   end

   assign queued_o         = queued_q;
   assign done_o           = done_q;
   assign fault_o          = fault_q;
   assign done_first_o     = ~(|done_q) & (|done_n);
   assign fault_any_next_o = |fault_n;

   // R9: the outstanding set is frozen while stopped and not releasing
   a_r9_queue_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped_i && !abort_i) |=> $stable(queued_q));

   // R3: a DONE bit appears only after a completion strobe
   a_r3_done_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      !done_en_i |=> ((done_q & ~$past(done_q)) == '0));

   // R8: a FAULT bit appears only after an error strobe
   a_r8_fault_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_en_i |=> ((fault_q & ~$past(fault_q)) == '0));
endmodule

// File: rtl/cplq_coal_timer.sv
module cplq_coal_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             load_i,
   input  logic [TMR_W-1:0] tmo_i,
   output logic             irq_o
);
   logic [TMR_W-1:0] cnt_q;
   logic             irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (load_i) begin
            cnt_q <= tmo_i;
         end else if (run_i) begin
            if (cnt_q == '0) begin
               cnt_q <= tmo_i;
               irq_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign irq_o = irq_q;

   // R7: an interrupt only follows a cycle in which completions were pending
   a_r7_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(run_i));

   // R6: a restart never fires in the same step
   a_r6_load_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !irq_q);
endmodule

// File: rtl/cplq_fault_ctl.sv
module cplq_fault_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_valid_i,
   input  logic devflt_clr_i,
   input  logic fault_any_next_i,
   input  logic issue_valid_i,
   output logic devflt_o,
   output logic stopped_o,
   output logic resume_o,
   output logic rejected_o
);
   logic devflt_q, stopped_q, rejected_q;
   logic devflt_n, stopped_n;

   assign devflt_n  = fault_valid_i | (devflt_q & ~devflt_clr_i);
   assign stopped_n = devflt_n | fault_any_next_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         devflt_q   <= 1'b0;
         stopped_q  <= 1'b0;
         rejected_q <= 1'b0;
      end else begin
         devflt_q   <= devflt_n;
         stopped_q  <= stopped_n;
         rejected_q <= issue_valid_i & stopped_q;
      end
   end

   assign devflt_o   = devflt_q;
   assign stopped_o  = stopped_q;
   assign resume_o   = stopped_q & ~stopped_n;
   assign rejected_o = rejected_q;

   // R9: an error strobe always freezes the queue
   a_r9_stop_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid_i |=> stopped_q);

   // R11: release never happens with the device-error flag still up
   a_r11_release_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stopped_q) |-> !devflt_q);

   // R10: a reject is only reported for a stopped queue
   a_r10_reject_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      rejected_q |-> $past(stopped_q));
endmodule

// File: rtl/cplq_regif.sv
module cplq_regif
   import cplq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int REG_W     = 32,
   parameter int TMR_W     = 16,
   parameter int TMO_RESET = 8,
   parameter int RD_LAT    = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [REG_W-1:0]     wdata_i,
   input  logic [NUM_SLOTS-1:0] queued_i,
   input  logic [NUM_SLOTS-1:0] done_i,
   input  logic [NUM_SLOTS-1:0] fault_i,
   input  logic                 devflt_i,
   output logic [NUM_SLOTS-1:0] done_clr_o,
   output logic [NUM_SLOTS-1:0] fault_clr_o,
   output logic                 devflt_clr_o,
   output logic [TMR_W-1:0]     tmo_o,
   output logic [REG_W-1:0]     rdata_o
);
   logic [TMR_W-1:0] tmo_q;
   logic [REG_W-1:0] rd_mux;
   logic             unused_wdata;

   assign unused_wdata = ^wdata_i;

   assign done_clr_o   = (wr_i && addr_i == RA_DONE)  ? wdata_i[NUM_SLOTS-1:0] : '0;
   assign fault_clr_o  = (wr_i && addr_i == RA_FAULT) ? wdata_i[NUM_SLOTS-1:0] : '0;
   assign devflt_clr_o = wr_i && (addr_i == RA_DEVFLT) && wdata_i[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tmo_q <= TMR_W'(TMO_RESET);
      else if (wr_i && addr_i == RA_TMO)
         tmo_q <= wdata_i[TMR_W-1:0];
   end
   assign tmo_o = tmo_q;

   always_comb begin
      rd_mux = '0;
      case (addr_i)
         RA_QUEUED: rd_mux[NUM_SLOTS-1:0] = queued_i;
         RA_DONE:   rd_mux[NUM_SLOTS-1:0] = done_i;
         RA_FAULT:  rd_mux[NUM_SLOTS-1:0] = fault_i;
         RA_DEVFLT: rd_mux[0]             = devflt_i;
         RA_TMO:    rd_mux[TMR_W-1:0]     = tmo_q;
         default:   rd_mux                = '0;
      endcase
   end

   if (RD_LAT == 0) begin : g_rd_comb
      assign rdata_o = rd_mux;
   end else begin : g_rd_reg
      logic [REG_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_mux;
      end
      assign rdata_o = rdata_q;
   end
endmodule

// File: rtl/cplq_tracker.sv
module cplq_tracker
   import cplq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int REG_W     = 32,
   parameter int TMR_W     = 16,
   parameter int TMO_RESET = 8,
   parameter int RD_LAT    = 0,
   localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [SLOT_W-1:0] issue_slot,
   input  logic              done_valid,
   input  logic [SLOT_W-1:0] done_slot,
   input  logic              fault_valid,
   input  logic [SLOT_W-1:0] fault_slot,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq,
   output logic              queue_stopped,
   output logic              issue_rejected
);
   if (NUM_SLOTS < 1 || NUM_SLOTS > REG_W) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 1..REG_W");
   end
   if (TMR_W < 1 || TMR_W > REG_W) begin : g_bad_tmr
      $error("TMR_W must lie in 1..REG_W");
   end
   if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
      $error("RD_LAT must be 0 or 1");
   end

   logic [NUM_SLOTS-1:0] queued_v, done_v, fault_v;
   logic [NUM_SLOTS-1:0] done_clr, fault_clr;
   logic                 devflt_clr, devflt, stopped, resume;
   logic                 done_first, fault_any_next, ack_hit;
   logic [TMR_W-1:0]     tmo;

   cplq_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) slots_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .issue_en_i       (issue_valid & ~stopped),
      .issue_slot_i     (issue_slot),
      .done_en_i        (done_valid & ~stopped),
      .done_slot_i      (done_slot),
      .fault_en_i       (fault_valid),
      .fault_slot_i     (fault_slot),
      .done_clr_i       (done_clr),
      .fault_clr_i      (fault_clr),
      .abort_i          (resume),
      .stopped_i        (stopped),
      .queued_o         (queued_v),
      .done_o           (done_v),
      .fault_o          (fault_v),
      .done_first_o     (done_first),
      .fault_any_next_o (fault_any_next)
   );

   cplq_fault_ctl fctl_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .fault_valid_i    (fault_valid),
      .devflt_clr_i     (devflt_clr),
      .fault_any_next_i (fault_any_next),
      .issue_valid_i    (issue_valid),
      .devflt_o         (devflt),
      .stopped_o        (stopped),
      .resume_o         (resume),
      .rejected_o       (issue_rejected)
   );

   cplq_regif #(
      .NUM_SLOTS (NUM_SLOTS),
      .REG_W     (REG_W),
      .TMR_W     (TMR_W),
      .TMO_RESET (TMO_RESET),
      .RD_LAT    (RD_LAT)
   ) regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (reg_wr),
      .addr_i       (reg_addr),
      .wdata_i      (reg_wdata),
      .queued_i     (queued_v),
      .done_i       (done_v),
      .fault_i      (fault_v),
      .devflt_i     (devflt),
      .done_clr_o   (done_clr),
      .fault_clr_o  (fault_clr),
      .devflt_clr_o (devflt_clr),
      .tmo_o        (tmo),
      .rdata_o      (reg_rdata)
   );

   assign ack_hit = |(done_clr & done_v);

   cplq_coal_timer #(.TMR_W(TMR_W)) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (|done_v),
      .load_i (done_first | ack_hit),
      .tmo_i  (tmo),
      .irq_o  (irq)
   );

   assign queue_stopped = stopped;
endmodule

// File: tb/cplq_tracker_tb_top.sv
module cplq_tracker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0, done_valid = 1'b0, fault_valid = 1'b0;
   logic [3:0]  issue_slot = '0, done_slot = '0, fault_slot = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, queue_stopped, issue_rejected;

   int checks = 0;
   int errors = 0;
   localparam int TMO = 8;

   always #2 clk = ~clk;

   cplq_tracker dut_i (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_slot(issue_slot),
      .done_valid(done_valid), .done_slot(done_slot),
      .fault_valid(fault_valid), .fault_slot(fault_slot),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq),
      .queue_stopped(queue_stopped), .issue_rejected(issue_rejected)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic do_issue(input int s);
      @(negedge clk);
      issue_valid = 1'b1; issue_slot = 4'(s);
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic do_done(input int s);
      @(negedge clk);
      done_valid = 1'b1; done_slot = 4'(s);
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   task automatic do_fault(input int s);
      @(negedge clk);
      fault_valid = 1'b1; fault_slot = 4'(s);
      @(negedge clk);
      fault_valid = 1'b0;
   endtask

   task automatic wait_irq(input int lim, output int j);
      j = 0;
      while (irq !== 1'b1 && j < lim) begin
         @(negedge clk);
         j++;
      end
   endtask

   task automatic clean_done();
      reg_write(3'd1, 32'hFFFF_FFFF);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reg_read(3'd0, d); chk("R1 QUEUED reset", d, 0);
      reg_read(3'd1, d); chk("R1 DONE reset", d, 0);
      reg_read(3'd2, d); chk("R1 FAULT reset", d, 0);
      reg_read(3'd3, d); chk("R1 DEVFLT reset", d, 0);
      reg_read(3'd4, d); chk("R1 TIMEOUT reset", d, TMO);
      chk("R1 outputs reset", {29'd0, irq, queue_stopped, issue_rejected}, 0);
   endtask

   task automatic t_issue_done();
      logic [31:0] d;
      do_issue(6);
      do_issue(11);
      reg_read(3'd0, d); chk("R2 issue sets QUEUED", d, 32'h0000_0840);
      reg_write(3'd0, 32'hFFFF_FFFF);
      reg_read(3'd0, d); chk("R2 QUEUED read-only", d, 32'h0000_0840);
      do_done(6);
      reg_read(3'd0, d); chk("R3 completion clears QUEUED", d, 32'h0000_0800);
      reg_read(3'd1, d); chk("R3 completion sets DONE, upper zero", d, 32'h0000_0040);
      do_done(11);
      reg_read(3'd1, d); chk("R3 second completion", d, 32'h0000_0840);
      reg_write(3'd1, 32'h0000_0040);
      reg_read(3'd1, d); chk("R4 write-1 clears DONE bit", d, 32'h0000_0800);
      reg_write(3'd1, 32'h0000_0000);
      reg_read(3'd1, d); chk("R4 write-0 keeps DONE", d, 32'h0000_0800);
      clean_done();
      reg_read(3'd1, d); chk("R4 clear all DONE", d, 0);
   endtask

   task automatic t_coalesce();
      int j;
      do_done(3);
      wait_irq(40, j); chk("R5 first irq delay", j, TMO + 1);
      @(negedge clk);  chk("R5 irq one cycle wide", {31'd0, irq}, 0);
      wait_irq(40, j); chk("R5 irq repeat period", j + 1, TMO + 1);
      clean_done();
   endtask

   task automatic t_ack_restart();
      int j;
      logic [31:0] d;
      do_done(1);
      repeat (3) @(negedge clk);
      do_done(2);
      wait_irq(40, j); chk("R6 later completion no restart", j, 4);
      reg_write(3'd1, 32'h0000_0002);
      wait_irq(40, j); chk("R6 ack restarts count", j, TMO + 1);
      reg_read(3'd1, d); chk("R6 ack clears only its bit", d, 32'h0000_0004);
      clean_done();
   endtask

   task automatic t_no_irq_idle();
      int j;
      do_done(4);
      repeat (3) @(negedge clk);
      reg_write(3'd1, 32'h0000_0010);
      wait_irq(40, j); chk("R7 no irq when DONE empty", j, 40);
   endtask

   task automatic t_timeout_reg();
      int j;
      logic [31:0] d;
      reg_write(3'd4, 32'h0000_0003);
      reg_read(3'd4, d); chk("R12 TIMEOUT readback", d, 3);
      do_done(0);
      wait_irq(40, j); chk("R12 new timeout used", j, 4);
      clean_done();
      reg_write(3'd4, TMO);
   endtask

   task automatic t_fault();
      logic [31:0] d;
      do_issue(2); do_issue(5); do_issue(9);
      do_fault(5);
      chk("R9 stopped after error", {31'd0, queue_stopped}, 1);
      reg_read(3'd3, d); chk("R9 DEVFLT set", d, 1);
      reg_read(3'd2, d); chk("R8 FAULT bit set", d, 32'h0000_0020);
      reg_read(3'd0, d); chk("R9 QUEUED kept", d, 32'h0000_0224);
      do_done(2);
      reg_read(3'd0, d); chk("R9 completion ignored QUEUED", d, 32'h0000_0224);
      reg_read(3'd1, d); chk("R9 completion ignored DONE", d, 0);
      do_issue(7);
      chk("R10 issue rejected pulse", {31'd0, issue_rejected}, 1);
      @(negedge clk);
      chk("R10 reject one cycle", {31'd0, issue_rejected}, 0);
      reg_read(3'd0, d); chk("R10 rejected issue no effect", d, 32'h0000_0224);
      reg_write(3'd2, 32'h0000_0000);
      reg_read(3'd2, d); chk("R8 write-0 keeps FAULT", d, 32'h0000_0020);
      reg_write(3'd3, 32'h0000_0001);
      chk("R11 still stopped with FAULT bit", {31'd0, queue_stopped}, 1);
      reg_read(3'd3, d); chk("R11 DEVFLT cleared", d, 0);
      reg_write(3'd2, 32'h0000_0020);
      chk("R11 released after both clears", {31'd0, queue_stopped}, 0);
      reg_read(3'd0, d); chk("R11 QUEUED aborted", d, 0);
      reg_read(3'd2, d); chk("R8 FAULT write-1 clears", d, 0);
      do_issue(7);
      chk("R11 issue accepted after release", {31'd0, issue_rejected}, 0);
      reg_read(3'd0, d); chk("R11 reissue sets QUEUED", d, 32'h0000_0080);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_issue_done();
      t_coalesce();
      t_ack_restart();
      t_no_irq_idle();
      t_timeout_reg();
      t_fault();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule